// File: doc/BRIEF.md
# Elastic Streaming Channel

This block is a word-wide, one-way, point-to-point streaming link made of a chain of identical elastic register stages. Each stage holds up to two words and speaks the same two-wire handshake on both sides. A valid flag travels with the data toward the consumer, and an accept flag travels back toward the producer. A word crosses any boundary only in a cycle where the sender shows valid and the receiver shows accept. The block treats control words and data words alike and passes every word through unchanged.

Every stage handles backpressure on its own. When the consumer stalls, the words already in flight pile up stage by stage, so none is dropped and the producer is throttled only once the whole chain is full. When neither side stalls, the chain moves one word per cycle. The accept that each stage returns upstream comes straight from its own state register and never passes through logic from the downstream accept. The parameter STAGES sets the length of the chain. It changes the latency and the capacity, never the order or the content of the stream.

Top module: `stream_channel`

## Requirements
- R1: In the cycle after reset is released, dn_vld is 0 and up_rdy is 1, because every stage starts empty.
- R2: A word is taken from the producer only on a clock edge where up_vld and up_rdy are both 1. A word offered while up_rdy is 0 is neither taken nor duplicated.
- R3: Words appear on dn_data in exactly the order they were accepted, each exactly once, with none lost.
- R4: Once dn_vld is 1 and dn_rdy is 0, the next cycle still shows dn_vld at 1 with dn_data unchanged.
- R5: With up_vld and dn_rdy both held at 1, the channel accepts a word every cycle and, once the first word arrives, delivers a word every cycle.
- R6: A word accepted into an empty channel first shows on dn_vld exactly STAGES cycles after the edge that accepted it.
- R7: With dn_rdy held at 0, the channel accepts exactly 2*STAGES words and then holds up_rdy at 0.
- R8: up_rdy does not change within a cycle when dn_rdy changes, because it is driven only from stage state registers.
- R9: Every bit pattern of the WIDTH-bit word passes through unchanged, including all zeros and all ones.
- R10: When the channel holds no word, dn_vld is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset; empties every stage |
| up_data | input | WIDTH | Word offered by the producer |
| up_vld | input | 1 | Producer has a word on up_data |
| up_rdy | output | 1 | Channel will take the offered word on this edge |
| dn_data | output | WIDTH | Word offered to the consumer |
| dn_vld | output | 1 | Channel has a word on dn_data |
| dn_rdy | input | 1 | Consumer takes the offered word on this edge |

## Verification
The hardest state to reach from the ports is a partly filled chain in which some stages hold two words and others hold one or none, with the consumer releasing while the producer is still pushing. Only in that state do the skid-to-main transfers and the accept flags within the chain all act at once. Random phases with uneven valid and accept densities (producer-heavy, consumer-heavy and balanced) leave the chain at scattered fill levels. Directed phases then stall the consumer until the chain is full and drain it completely, and every delivered word is compared with a reference queue.

// File: rtl/chan_pkg.sv
package chan_pkg;

  // Fill level of one elastic stage: nothing, main register only, main plus skid.
  typedef enum logic [1:0] {
    FILL_NONE = 2'd0,
    FILL_ONE  = 2'd1,
    FILL_TWO  = 2'd2
  } fill_e;

endpackage

// File: rtl/elastic_ctrl.sv
module elastic_ctrl
  import chan_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic in_vld,
  input  logic out_rdy,
  output logic in_rdy,
  output logic out_vld,
  output logic load_main,
  output logic load_side,
  output logic main_sel_side
);

  fill_e fill_q, fill_d;
  logic  take_in;
  logic  give_out;

  // Both flags are plain decodes of the state register.
  assign in_rdy   = (fill_q != FILL_TWO);
  assign out_vld  = (fill_q != FILL_NONE);
  assign take_in  = in_vld && in_rdy;
  assign give_out = out_vld && out_rdy;

  always_comb begin
    fill_d        = fill_q;
    load_main     = 1'b0;
    load_side     = 1'b0;
    main_sel_side = 1'b0;
    unique case (fill_q)
      FILL_NONE: begin
        if (take_in) begin
          load_main = 1'b1;
          fill_d    = FILL_ONE;
        end
      end
      FILL_ONE: begin
        if (take_in && give_out) begin
          load_main = 1'b1;
        end else if (take_in) begin
          load_side = 1'b1;
          fill_d    = FILL_TWO;
        end else if (give_out) begin
          fill_d    = FILL_NONE;
        end
      end
      FILL_TWO: begin
        if (give_out) begin
          load_main     = 1'b1;
          main_sel_side = 1'b1;
          fill_d        = FILL_ONE;
        end
      end
      default: fill_d = FILL_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) fill_q <= FILL_NONE;
    else     fill_q <= fill_d;
  end

endmodule

// File: rtl/elastic_regs.sv
module elastic_regs #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             load_main,
  input  logic             load_side,
  input  logic             main_sel_side,
  input  logic [WIDTH-1:0] in_data,
  output logic [WIDTH-1:0] out_data
);

  logic [WIDTH-1:0] main_q;
  logic [WIDTH-1:0] side_q;

  // Data registers carry no reset; the valid state in elastic_ctrl guards them.
  always_ff @(posedge clk) begin
    if (load_side) side_q <= in_data;
    if (load_main) main_q <= main_sel_side ? side_q : in_data;
  end

  assign out_data = main_q;

endmodule

// File: rtl/elastic_stage.sv
module elastic_stage #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] in_data,
  input  logic             in_vld,
  output logic             in_rdy,
  output logic [WIDTH-1:0] out_data,
  output logic             out_vld,
  input  logic             out_rdy
);

  logic load_main;
  logic load_side;
  logic main_sel_side;

  elastic_ctrl u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .in_vld        (in_vld),
    .out_rdy       (out_rdy),
    .in_rdy        (in_rdy),
    .out_vld       (out_vld),
    .load_main     (load_main),
    .load_side     (load_side),
    .main_sel_side (main_sel_side)
  );

  elastic_regs #(.WIDTH(WIDTH)) u_regs (
    .clk           (clk),
    .load_main     (load_main),
    .load_side     (load_side),
    .main_sel_side (main_sel_side),
    .in_data       (in_data),
    .out_data      (out_data)
  );

endmodule

// File: rtl/stream_channel.sv
module stream_channel #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] up_data,
  input  logic             up_vld,
  output logic             up_rdy,
  output logic [WIDTH-1:0] dn_data,
  output logic             dn_vld,
  input  logic             dn_rdy
);

  localparam int unsigned LINKS = STAGES + 1;

  logic [WIDTH-1:0] link_data [LINKS];
  logic             link_vld  [LINKS];
  logic             link_rdy  [LINKS];

  assign link_data[0]      = up_data;
  assign link_vld[0]       = up_vld;
  assign up_rdy            = link_rdy[0];
  assign dn_data           = link_data[STAGES];
  assign dn_vld            = link_vld[STAGES];
  assign link_rdy[STAGES]  = dn_rdy;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    elastic_stage #(.WIDTH(WIDTH)) u_stage (
      .clk      (clk),
      .rst      (rst),
      .in_data  (link_data[g]),
      .in_vld   (link_vld[g]),
      .in_rdy   (link_rdy[g]),
      .out_data (link_data[g+1]),
      .out_vld  (link_vld[g+1]),
      .out_rdy  (link_rdy[g+1])
    );
  end

endmodule

// File: rtl/stream_channel_chk.sv
module stream_channel_chk #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 3
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] up_data,
  input logic             up_vld,
  input logic             up_rdy,
  input logic [WIDTH-1:0] dn_data,
  input logic             dn_vld,
  input logic             dn_rdy
);

  localparam int unsigned CAP   = 2 * STAGES;
  localparam int unsigned OCC_W = $clog2(CAP + 2) + 1;

  logic [OCC_W-1:0] occ_q;
  logic             rst_q;
  logic             up_fire;
  logic             dn_fire;
  logic [WIDTH-1:0] unused_up_data;

  assign up_fire        = up_vld && up_rdy;
  assign dn_fire        = dn_vld && dn_rdy;
  assign unused_up_data = up_data;

  // Words held in the channel, counted only from port handshakes.
  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) occ_q <= '0;
    else     occ_q <= occ_q + OCC_W'(up_fire) - OCC_W'(dn_fire);
  end

  // R1
  always @(posedge clk) begin
    if (rst_q === 1'b1 && rst === 1'b0) begin
      reset_state_chk: assert (!dn_vld && up_rdy);
    end
  end

  // R4
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (dn_vld && !dn_rdy) |=> (dn_vld && $stable(dn_data)));

  // R7
  capacity_chk: assert property (@(posedge clk) disable iff (rst)
    (32'(occ_q) <= CAP));

  // R7
  full_block_chk: assert property (@(posedge clk) disable iff (rst)
    (32'(occ_q) == CAP) |-> !up_rdy);

  // R10
  empty_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (occ_q == '0) |-> !dn_vld);

  // R3
  no_phantom_chk: assert property (@(posedge clk) disable iff (rst)
    dn_fire |-> (occ_q != '0));

endmodule

bind stream_channel stream_channel_chk #(.WIDTH(WIDTH), .STAGES(STAGES)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .up_data (up_data),
  .up_vld  (up_vld),
  .up_rdy  (up_rdy),
  .dn_data (dn_data),
  .dn_vld  (dn_vld),
  .dn_rdy  (dn_rdy)
);

// File: tb/stream_channel_tb.sv
module stream_channel_tb;

  localparam int unsigned WIDTH  = 32;
  localparam int unsigned STAGES = 3;
  localparam int unsigned CAP    = 2 * STAGES;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [WIDTH-1:0] up_data = '0;
  logic             up_vld = 1'b0;
  logic             up_rdy;
  logic [WIDTH-1:0] dn_data;
  logic             dn_vld;
  logic             dn_rdy = 1'b0;

  always #10 clk = ~clk;

  stream_channel #(.WIDTH(WIDTH), .STAGES(STAGES)) u_dut (
    .clk     (clk),
    .rst     (rst),
    .up_data (up_data),
    .up_vld  (up_vld),
    .up_rdy  (up_rdy),
    .dn_data (dn_data),
    .dn_vld  (dn_vld),
    .dn_rdy  (dn_rdy)
  );

  int unsigned      n_checks = 0;
  int unsigned      n_fail   = 0;
  int unsigned      word_idx = 0;
  int unsigned      push_cnt = 0;
  int unsigned      pop_cnt  = 0;
  logic [WIDTH-1:0] ref_q [$];
  logic             pending   = 1'b0;
  logic             was_stall = 1'b0;
  logic [WIDTH-1:0] stall_data = '0;
  logic             saw_ones  = 1'b0;
  logic             saw_zero  = 1'b0;

  task automatic check(input bit ok, input string req, input logic [WIDTH-1:0] act,
                       input logic [WIDTH-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [WIDTH-1:0] gen_word(input int unsigned idx);
    if (idx % 7 == 3)       return '1;
    else if (idx % 11 == 5) return '0;
    else                    return WIDTH'($urandom);
  endfunction

  // One cycle: drive at the falling edge, observe 1 ns later; transfers happen at the next rising edge.
  task automatic cycle(input bit want_push, input bit want_pop);
    logic rdy_before;
    @(negedge clk);
    rdy_before = up_rdy;
    if (!pending) begin
      up_vld = want_push;
      if (want_push) begin
        up_data = gen_word(word_idx);
        word_idx++;
      end
    end
    dn_rdy = want_pop;
    #1;
    // R8: up_rdy is unaffected by the dn_rdy change in this cycle
    check(up_rdy == rdy_before, "R8", WIDTH'(up_rdy), WIDTH'(rdy_before));
    if (was_stall) begin
      // R4
      check(dn_vld == 1'b1, "R4 valid held", WIDTH'(dn_vld), WIDTH'(1));
      check(dn_data == stall_data, "R4 data held", dn_data, stall_data);
    end
    if (up_vld && up_rdy) begin
      ref_q.push_back(up_data);
      push_cnt++;
    end
    pending = up_vld && !up_rdy;
    if (dn_vld && dn_rdy) begin
      pop_cnt++;
      if (ref_q.size() == 0) begin
        // R10
        check(1'b0, "R10 word from empty channel", dn_data, '0);
      end else begin
        logic [WIDTH-1:0] exp_w;
        exp_w = ref_q.pop_front();
        // R3 / R9
        check(dn_data == exp_w, "R3 order and R9 content", dn_data, exp_w);
        if (exp_w == '1) saw_ones = 1'b1;
        if (exp_w == '0) saw_zero = 1'b1;
      end
    end
    was_stall  = dn_vld && !dn_rdy;
    stall_data = dn_data;
  endtask

  task automatic drain();
    for (int i = 0; i < 4 * CAP + 8; i++) cycle(1'b0, 1'b1);
  endtask

  task automatic random_phase(input int unsigned n, input int unsigned push_pct,
                              input int unsigned pop_pct);
    for (int i = 0; i < n; i++)
      cycle(($urandom % 100) < push_pct, ($urandom % 100) < pop_pct);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_C0DE));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    check(dn_vld == 1'b0, "R1 dn_vld after reset", WIDTH'(dn_vld), '0);
    check(up_rdy == 1'b1, "R1 up_rdy after reset", WIDTH'(up_rdy), WIDTH'(1));

    // R10: an idle empty channel offers nothing
    for (int i = 0; i < 5; i++) begin
      cycle(1'b0, 1'b1);
      check(dn_vld == 1'b0, "R10 idle empty", WIDTH'(dn_vld), '0);
    end

    // R6: latency through an empty channel
    cycle(1'b1, 1'b1);
    for (int k = 1; k <= int'(STAGES); k++) begin
      cycle(1'b0, 1'b1);
      check(dn_vld == (k == int'(STAGES)), "R6 latency", WIDTH'(dn_vld),
            WIDTH'(k == int'(STAGES)));
    end
    drain();

    // R7 / R2: stall the consumer and keep offering
    begin
      int unsigned base;
      base = push_cnt;
      for (int i = 0; i < 4 * CAP; i++) cycle(1'b1, 1'b0);
      check(push_cnt - base == CAP, "R7 capacity", WIDTH'(push_cnt - base), WIDTH'(CAP));
      check(up_rdy == 1'b0, "R7 up_rdy when full", WIDTH'(up_rdy), '0);
      check(pending == 1'b1, "R2 offered word not taken", WIDTH'(pending), WIDTH'(1));
    end
    drain();
    // R2: repeated offering while blocked neither lost nor duplicated a word
    check(push_cnt == pop_cnt, "R2 pushes equal pops", WIDTH'(pop_cnt), WIDTH'(push_cnt));
    check(ref_q.size() == 0, "R2 queue empty", WIDTH'(ref_q.size()), '0);

    // R5: full throughput with both sides always willing
    begin
      int unsigned vld_cycles;
      int unsigned rdy_cycles;
      vld_cycles = 0;
      rdy_cycles = 0;
      for (int i = 0; i < int'(STAGES); i++) cycle(1'b1, 1'b1);
      for (int i = 0; i < 40; i++) begin
        cycle(1'b1, 1'b1);
        if (dn_vld) vld_cycles++;
        if (up_rdy) rdy_cycles++;
      end
      check(vld_cycles == 40, "R5 output every cycle", WIDTH'(vld_cycles), WIDTH'(40));
      check(rdy_cycles == 40, "R5 input every cycle", WIDTH'(rdy_cycles), WIDTH'(40));
    end
    drain();

    // Random mixes leave the chain at scattered fill levels
    random_phase(3000, 80, 30);
    random_phase(3000, 30, 80);
    random_phase(3000, 60, 60);
    random_phase(1000, 95, 95);
    drain();

    check(ref_q.size() == 0, "R3 no word lost", WIDTH'(ref_q.size()), '0);
    check(push_cnt == pop_cnt, "R3 count match", WIDTH'(pop_cnt), WIDTH'(push_cnt));
    check(saw_ones && saw_zero, "R9 extreme patterns seen", WIDTH'({saw_ones, saw_zero}),
          WIDTH'(3));
    check(dn_vld == 1'b0, "R10 drained", WIDTH'(dn_vld), '0);
    finish_run();
  end

endmodule